// File: doc/BRIEF.md
# Endpoint Status Byte Updater

This block maintains the status byte at the head of each endpoint descriptor for a USB device controller. The descriptors sit in a shared byte-wide memory at an offset from a movable base pointer. The controller's transaction engine reports one event at a time: an endpoint number, a direction, an endpoint kind and a set of outcome pulses. The block turns these into the flag bits that the event sets, then updates the stored byte with a read-modify-write over a single-port memory port whose read data arrives one cycle after the read.

Firmware clears flags by presenting an endpoint, a direction and a mask in which every one bit clears the matching flag. Suppose a hardware event and a software clear are accepted together and target the same descriptor. They are then folded into one update in which a set beats a clear, so no event is lost. If they target different descriptors, the event is written first and the clear follows directly after it. While an update is in flight the block raises `busy`, and it takes no new request.

Top module: `ep_status_updater`

## Requirements
- R1: After reset, `busy`, `mem_req` and `mem_we` are 0.
- R2: The status byte of an endpoint is at `base_ptr + 16*ep` for the output direction (`dir_in`=0) and at `base_ptr + 16*ep + 8` for the input direction (`dir_in`=1), modulo 2^16.
- R3: Bit 7 is the halt/error flag. For kinds control (2'b00), bulk/interrupt (2'b01) and reserved (2'b11), the stall pulse sets it. For the isochronous kind (2'b10), only the CRC-error pulse on the output direction sets it, and the stall pulse has no effect.
- R4: Bit 6 is set by the not-ready pulse in either direction (underflow on input, overflow on output).
- R5: The transfer-done pulse sets bits 5 and 4. The setup-done pulse sets bit 4 only on the control kind and is ignored on every other kind.
- R6: A request is accepted on a clock edge where `busy` is 0. In the next cycle the block issues a read (`mem_req`=1, `mem_we`=0) to the descriptor address. In the cycle after that it writes back to the same address, using the read data that arrives in that cycle. `busy` is high for exactly those two cycles.
- R7: Bits 3 to 0 are written back exactly as read. `clr_mask[3:0]` has no effect.
- R8: A one in `clr_mask[7:4]` clears that flag. A zero leaves it unchanged, and so does every flag the event does not set.
- R9: An event and a clear accepted in the same cycle for the same descriptor make a single read-modify-write (busy for 2 cycles). In it, a bit that is both set and cleared ends up as 1.
- R10: An event and a clear accepted in the same cycle for different descriptors make two back-to-back read-modify-writes, the event's first (busy for 4 cycles).
- R11: `ev_valid` and `clr_valid` are ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_ptr | input | 16 | Descriptor table base address |
| ev_valid | input | 1 | Hardware event present |
| ev_ep | input | 4 | Event endpoint number |
| ev_dir_in | input | 1 | Event direction, 1 = input endpoint |
| ev_kind | input | 2 | Endpoint kind: 00 control, 01 bulk/interrupt, 10 isochronous, 11 reserved |
| ev_stall | input | 1 | Transaction answered with STALL |
| ev_crc_err | input | 1 | CRC error in received data |
| ev_not_ready | input | 1 | Endpoint was not ready (underflow/overflow) |
| ev_xfer_done | input | 1 | IN or OUT transaction completed |
| ev_setup_done | input | 1 | SETUP transaction completed |
| clr_valid | input | 1 | Software clear present |
| clr_ep | input | 4 | Clear endpoint number |
| clr_dir_in | input | 1 | Clear direction, 1 = input endpoint |
| clr_mask | input | 8 | Write-one-to-clear mask |
| busy | output | 1 | Update in progress; requests ignored |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after a read |

## Verification
Most internal faults land in the descriptor memory. A bad flag mapping or merge term leaves a wrong byte at the descriptor address within two cycles of acceptance. A bad address adder writes a neighbouring descriptor and leaves the expected one stale. A fault in the sequencer shows at once as a wrong `busy` length, or as a write that does not follow its read to the same address. A lost pending clear surfaces four cycles after acceptance as a flag that is still set.

// File: rtl/ep_stat_pkg.sv
package ep_stat_pkg;
   typedef enum logic [1:0] {
      EPK_CTRL = 2'b00,
      EPK_BULK = 2'b01,
      EPK_ISO  = 2'b10,
      EPK_RSVD = 2'b11
   } ep_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_READ  = 2'b01,
      ST_WRITE = 2'b10
   } upd_state_e;

   localparam int FLAG_CNT = 4;  // flags live in the top bits of the status byte
   localparam int B_HALT   = 3;  // index within the flag nibble (byte bit 7)
   localparam int B_STARVE = 2;  // byte bit 6
   localparam int B_DONE   = 1;  // byte bit 5
   localparam int B_DONE2  = 0;  // byte bit 4
endpackage

// File: rtl/ep_addr_gen.sv
module ep_addr_gen #(
   parameter int ADDR_W     = 16,
   parameter int EP_W       = 4,
   parameter int DESC_BYTES = 8
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [EP_W-1:0]   ep,
   input  logic              dir_in,
   output logic [ADDR_W-1:0] addr
);
   localparam int SLOT_SH = $clog2(DESC_BYTES);
   localparam int IDX_W   = EP_W + 1;

   logic [IDX_W-1:0]  slot;
   logic [ADDR_W-1:0] offset;

   always_comb begin
      slot   = {ep, dir_in};
      offset = ADDR_W'(slot) << SLOT_SH;
      addr   = base + offset;
   end
endmodule

// File: rtl/ep_flag_map.sv
module ep_flag_map
   import ep_stat_pkg::*;
(
   input  logic [1:0]          kind,
   input  logic                dir_in,
   input  logic                stall,
   input  logic                crc_err,
   input  logic                not_ready,
   input  logic                xfer_done,
   input  logic                setup_done,
   output logic [FLAG_CNT-1:0] set_flags
);
   ep_kind_e k;

   always_comb begin
      k = ep_kind_e'(kind);
      set_flags = '0;
      if (k == EPK_ISO) set_flags[B_HALT] = crc_err & ~dir_in;
      else              set_flags[B_HALT] = stall;
      set_flags[B_STARVE] = not_ready;
      set_flags[B_DONE]   = xfer_done;
      set_flags[B_DONE2]  = xfer_done | (setup_done & (k == EPK_CTRL));
   end
endmodule

// File: rtl/ep_status_merge.sv
module ep_status_merge #(
   parameter int DATA_W = 8,
   parameter int FLAGS  = 4
) (
   input  logic [DATA_W-1:0] old_byte,
   input  logic [FLAGS-1:0]  set_flags,
   input  logic [FLAGS-1:0]  clr_flags,
   output logic [DATA_W-1:0] new_byte
);
   localparam int KEEP_W = DATA_W - FLAGS;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i >= KEEP_W) begin : g_flag
         // set has priority over a simultaneous clear
         assign new_byte[i] = set_flags[i-KEEP_W] |
                              (old_byte[i] & ~clr_flags[i-KEEP_W]);
      end else begin : g_keep
         assign new_byte[i] = old_byte[i];
      end
   end
endmodule

// File: rtl/ep_status_updater.sv
module ep_status_updater
   import ep_stat_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int NUM_EP     = 16,
   parameter int DESC_BYTES = 8,
   parameter int DATA_W     = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       base_ptr,
   input  logic                    ev_valid,
   input  logic [$clog2(NUM_EP)-1:0] ev_ep,
   input  logic                    ev_dir_in,
   input  logic [1:0]              ev_kind,
   input  logic                    ev_stall,
   input  logic                    ev_crc_err,
   input  logic                    ev_not_ready,
   input  logic                    ev_xfer_done,
   input  logic                    ev_setup_done,
   input  logic                    clr_valid,
   input  logic [$clog2(NUM_EP)-1:0] clr_ep,
   input  logic                    clr_dir_in,
   input  logic [DATA_W-1:0]       clr_mask,
   output logic                    busy,
   output logic                    mem_req,
   output logic                    mem_we,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [DATA_W-1:0]       mem_wdata,
   input  logic [DATA_W-1:0]       mem_rdata
);
   localparam int EP_W = $clog2(NUM_EP);

   initial begin
      assert (DATA_W == 8) else $error("status byte must be 8 bits");
      assert (DESC_BYTES >= 2 && (DESC_BYTES & (DESC_BYTES - 1)) == 0)
         else $error("DESC_BYTES must be a power of two");
      assert (ADDR_W > EP_W + $clog2(DESC_BYTES))
         else $error("ADDR_W too small for descriptor table");
   end

   logic [ADDR_W-1:0]   ev_addr, clr_addr;
   logic [FLAG_CNT-1:0] ev_set, clr_hi;
   upd_state_e          state;
   logic [ADDR_W-1:0]   op_addr, pend_addr;
   logic [FLAG_CNT-1:0] op_set, op_clr, pend_clr;
   logic                pend_v;
   logic                idle, take_ev, take_clr, same_desc;

   ep_addr_gen #(.ADDR_W(ADDR_W), .EP_W(EP_W), .DESC_BYTES(DESC_BYTES)) u_ev_addr (
      .base(base_ptr), .ep(ev_ep), .dir_in(ev_dir_in), .addr(ev_addr));

   ep_addr_gen #(.ADDR_W(ADDR_W), .EP_W(EP_W), .DESC_BYTES(DESC_BYTES)) u_clr_addr (
      .base(base_ptr), .ep(clr_ep), .dir_in(clr_dir_in), .addr(clr_addr));

   ep_flag_map u_map (
      .kind(ev_kind), .dir_in(ev_dir_in), .stall(ev_stall), .crc_err(ev_crc_err),
      .not_ready(ev_not_ready), .xfer_done(ev_xfer_done), .setup_done(ev_setup_done),
      .set_flags(ev_set));

   ep_status_merge #(.DATA_W(DATA_W), .FLAGS(FLAG_CNT)) u_merge (
      .old_byte(mem_rdata), .set_flags(op_set), .clr_flags(op_clr), .new_byte(mem_wdata));

   assign clr_hi    = clr_mask[DATA_W-1 -: FLAG_CNT];
   assign idle      = (state == ST_IDLE);
   assign take_ev   = idle & ev_valid;
   assign take_clr  = idle & clr_valid;
   assign same_desc = (ev_addr == clr_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         op_addr   <= '0;
         op_set    <= '0;
         op_clr    <= '0;
         pend_v    <= 1'b0;
         pend_addr <= '0;
         pend_clr  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (take_ev) begin
                  op_addr   <= ev_addr;
                  op_set    <= ev_set;
                  op_clr    <= (take_clr && same_desc) ? clr_hi : '0;
                  pend_v    <= take_clr && !same_desc;
                  pend_addr <= clr_addr;
                  pend_clr  <= clr_hi;
                  state     <= ST_READ;
               end else if (take_clr) begin
                  op_addr <= clr_addr;
                  op_set  <= '0;
                  op_clr  <= clr_hi;
                  state   <= ST_READ;
               end
            end
            ST_READ: state <= ST_WRITE;
            ST_WRITE: begin
               if (pend_v) begin
                  op_addr <= pend_addr;
                  op_set  <= '0;
                  op_clr  <= pend_clr;
                  pend_v  <= 1'b0;
                  state   <= ST_READ;
               end else begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = !idle;
   assign mem_req  = (state == ST_READ) || (state == ST_WRITE);
   assign mem_we   = (state == ST_WRITE);
   assign mem_addr = op_addr;
endmodule

// File: rtl/ep_status_updater_chk.sv
module ep_status_updater_chk #(
   parameter int ADDR_W     = 16,
   parameter int DESC_BYTES = 8,
   parameter int DATA_W     = 8,
   parameter int NUM_EP     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] base_ptr,
   input logic              ev_valid,
   input logic              clr_valid,
   input logic              busy,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata
);
   localparam int SLOT_SH = $clog2(DESC_BYTES);
   localparam int SPAN    = 2 * NUM_EP * DESC_BYTES;

   logic [ADDR_W-1:0] rel;
   assign rel = mem_addr - base_ptr;

   // R1: memory port quiet out of reset
   a_r1_quiet_reset: assert property (@(posedge clk)
      !rst_n |=> (!mem_req && !busy));

   // R2: every access lands on a descriptor boundary inside the table
   a_r2_desc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (rel[SLOT_SH-1:0] == '0 && int'(rel) < SPAN));

   // R6: accepted request leads to a read on the next cycle
   a_r6_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_valid || clr_valid) && !busy) |=> (mem_req && !mem_we));

   // R6: a write always follows a read of the same address
   a_r6_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(mem_req) && !$past(mem_we) && mem_addr == $past(mem_addr)));

   // R6: memory is only used while busy
   a_r6_mem_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   // R7: low bits of the status byte come back unchanged
   a_r7_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata[3:0] == mem_rdata[3:0]));
endmodule

bind ep_status_updater ep_status_updater_chk #(
   .ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES), .DATA_W(DATA_W), .NUM_EP(NUM_EP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .base_ptr(base_ptr), .ev_valid(ev_valid),
   .clr_valid(clr_valid), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
);

// File: tb/ep_status_updater_bench.sv
module ep_status_updater_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_D      = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] base_ptr = '0;
   logic        ev_valid = 1'b0, ev_dir_in = 1'b0;
   logic [3:0]  ev_ep = '0;
   logic [1:0]  ev_kind = '0;
   logic        ev_stall = 1'b0, ev_crc_err = 1'b0, ev_not_ready = 1'b0;
   logic        ev_xfer_done = 1'b0, ev_setup_done = 1'b0;
   logic        clr_valid = 1'b0, clr_dir_in = 1'b0;
   logic [3:0]  clr_ep = '0;
   logic [7:0]  clr_mask = '0;
   logic        busy, mem_req, mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;

   logic [7:0]  mem [MEM_D];
   logic [7:0]  exp_mem [MEM_D];
   logic [15:0] last_wr_addr;
   int          checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ep_status_updater u_ep_status_updater (
      .clk(clk), .rst_n(rst_n), .base_ptr(base_ptr),
      .ev_valid(ev_valid), .ev_ep(ev_ep), .ev_dir_in(ev_dir_in), .ev_kind(ev_kind),
      .ev_stall(ev_stall), .ev_crc_err(ev_crc_err), .ev_not_ready(ev_not_ready),
      .ev_xfer_done(ev_xfer_done), .ev_setup_done(ev_setup_done),
      .clr_valid(clr_valid), .clr_ep(clr_ep), .clr_dir_in(clr_dir_in), .clr_mask(clr_mask),
      .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

   // single-port memory, read data one cycle after request
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata;
            last_wr_addr       <= mem_addr;
         end
         mem_rdata <= mem[mem_addr[9:0]];
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   function automatic logic [15:0] desc_addr(input logic [15:0] b, input logic [3:0] ep,
                                             input logic dir);
      return b + 16'(ep) * 16'd16 + (dir ? 16'd8 : 16'd0);
   endfunction

   function automatic logic [7:0] set_bits(input logic [1:0] kind, input logic dir,
      input logic st, input logic crc, input logic nr, input logic dn, input logic su);
      logic [7:0] s = '0;
      s[7] = (kind == 2'b10) ? (crc & ~dir) : st;
      s[6] = nr;
      s[5] = dn;
      s[4] = dn | (su & (kind == 2'b00));
      return s;
   endfunction

   task automatic run_op(input logic ev_v, input logic [3:0] e_ep, input logic e_dir,
      input logic [1:0] kind, input logic st, input logic crc, input logic nr,
      input logic dn, input logic su,
      input logic c_v, input logic [3:0] c_ep, input logic c_dir, input logic [7:0] cm,
      input string req);
      logic [15:0] ea, ca;
      logic [7:0]  s, cmk;
      int          exp_cyc, n;
      ea  = desc_addr(base_ptr, e_ep, e_dir);
      ca  = desc_addr(base_ptr, c_ep, c_dir);
      s   = set_bits(kind, e_dir, st, crc, nr, dn, su);
      cmk = {cm[7:4], 4'h0};
      if (ev_v && c_v && ea == ca) begin
         exp_mem[ea[9:0]] = (exp_mem[ea[9:0]] & ~cmk) | s;
         exp_cyc = 2;
      end else begin
         if (ev_v) exp_mem[ea[9:0]] = exp_mem[ea[9:0]] | s;
         if (c_v)  exp_mem[ca[9:0]] = exp_mem[ca[9:0]] & ~cmk;
         exp_cyc = (ev_v && c_v) ? 4 : 2;
      end
      ev_valid = ev_v; ev_ep = e_ep; ev_dir_in = e_dir; ev_kind = kind;
      ev_stall = st; ev_crc_err = crc; ev_not_ready = nr;
      ev_xfer_done = dn; ev_setup_done = su;
      clr_valid = c_v; clr_ep = c_ep; clr_dir_in = c_dir; clr_mask = cm;
      @(negedge clk);
      ev_valid = 1'b0; clr_valid = 1'b0;
      n = 0;
      while (busy && n < 20) begin
         n++;
         @(negedge clk);
      end
      check(n == exp_cyc, {req, " busy length"}, n, exp_cyc);
      if (ev_v) check(mem[ea[9:0]] == exp_mem[ea[9:0]], {req, " event byte"},
                      mem[ea[9:0]], exp_mem[ea[9:0]]);
      if (c_v)  check(mem[ca[9:0]] == exp_mem[ca[9:0]], {req, " clear byte"},
                      mem[ca[9:0]], exp_mem[ca[9:0]]);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < MEM_D; i++) begin
         mem[i] = 8'($urandom);
         exp_mem[i] = mem[i];
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      check(busy == 1'b0 && mem_req == 1'b0 && mem_we == 1'b0, "R1 reset", {busy, mem_req, mem_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      base_ptr = 16'h0120;

      // R3: stall on bulk output, crc on iso output, stall ignored on iso, crc ignored on iso input
      mem[16'h0150 & 10'h3ff] = 8'h05; exp_mem[16'h0150 & 10'h3ff] = 8'h05;
      run_op(1, 4'd3, 0, 2'b01, 1, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R3 bulk stall");
      check(mem[10'h150] == 8'h85, "R3 stall bit7", mem[10'h150], 8'h85);
      check(last_wr_addr == 16'h0150, "R2 write address", last_wr_addr, 16'h0150);
      mem[10'h170] = 8'h00; exp_mem[10'h170] = 8'h00;
      run_op(1, 4'd5, 0, 2'b10, 1, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R3 iso stall ignored");
      check(mem[10'h170] == 8'h00, "R3 iso stall no effect", mem[10'h170], 8'h00);
      run_op(1, 4'd5, 0, 2'b10, 0, 1, 0, 0, 0, 0, 0, 0, 8'h00, "R3 iso crc out");
      check(mem[10'h170] == 8'h80, "R3 iso crc bit7", mem[10'h170], 8'h80);
      mem[10'h178] = 8'h00; exp_mem[10'h178] = 8'h00;
      run_op(1, 4'd5, 1, 2'b10, 0, 1, 0, 0, 0, 0, 0, 0, 8'h00, "R3 iso crc in ignored");
      check(mem[10'h178] == 8'h00, "R3 iso in crc no effect", mem[10'h178], 8'h00);
      check(last_wr_addr == 16'h0178, "R2 input offset", last_wr_addr, 16'h0178);

      // R4: not-ready on both directions
      run_op(1, 4'd1, 1, 2'b01, 0, 0, 1, 0, 0, 0, 0, 0, 8'h00, "R4 underflow in");
      run_op(1, 4'd2, 0, 2'b01, 0, 0, 1, 0, 0, 0, 0, 0, 8'h00, "R4 overflow out");

      // R5: setup on control vs bulk, transfer done
      mem[10'h120] = 8'h00; exp_mem[10'h120] = 8'h00;
      run_op(1, 4'd0, 0, 2'b00, 0, 0, 0, 0, 1, 0, 0, 0, 8'h00, "R5 control setup");
      check(mem[10'h120] == 8'h10, "R5 setup bit4", mem[10'h120], 8'h10);
      mem[10'h190] = 8'h00; exp_mem[10'h190] = 8'h00;
      run_op(1, 4'd7, 0, 2'b01, 0, 0, 0, 0, 1, 0, 0, 0, 8'h00, "R5 bulk setup ignored");
      check(mem[10'h190] == 8'h00, "R5 bulk setup no effect", mem[10'h190], 8'h00);
      run_op(1, 4'd7, 0, 2'b01, 0, 0, 0, 1, 0, 0, 0, 0, 8'h00, "R5 xfer done");
      check(mem[10'h190] == 8'h30, "R5 done bits5-4", mem[10'h190], 8'h30);

      // R8: write-one-to-clear on part of the flags
      mem[10'h150] = 8'hF3; exp_mem[10'h150] = 8'hF3;
      run_op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd3, 0, 8'hA0, "R8 w1c");
      check(mem[10'h150] == 8'h53, "R8 cleared ones only", mem[10'h150], 8'h53);

      // R7: low mask bits ignored
      run_op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd3, 0, 8'h0F, "R7 low mask");
      check(mem[10'h150] == 8'h53, "R7 low bits kept", mem[10'h150], 8'h53);

      // R9: same descriptor, set wins
      mem[10'h120] = 8'h3A; exp_mem[10'h120] = 8'h3A;
      run_op(1, 4'd0, 0, 2'b00, 0, 0, 0, 0, 1, 1, 4'd0, 0, 8'hF0, "R9 set wins");
      check(mem[10'h120] == 8'h1A, "R9 merged result", mem[10'h120], 8'h1A);

      // R10: different descriptors, event then clear
      mem[10'h130] = 8'h00; exp_mem[10'h130] = 8'h00;
      mem[10'h138] = 8'hC1; exp_mem[10'h138] = 8'hC1;
      run_op(1, 4'd1, 0, 2'b01, 1, 0, 0, 0, 0, 1, 4'd1, 1, 8'hFF, "R10 split");
      check(mem[10'h130] == 8'h80 && mem[10'h138] == 8'h01, "R10 both bytes",
            {mem[10'h130], mem[10'h138]}, 16'h8001);

      // R11: request during busy ignored
      mem[10'h1A0] = 8'h00; exp_mem[10'h1A0] = 8'h00;
      mem[10'h1B0] = 8'hF0; exp_mem[10'h1B0] = 8'hF0;
      begin
         int n = 0;
         ev_valid = 1; ev_ep = 4'd8; ev_dir_in = 0; ev_kind = 2'b01;
         ev_stall = 0; ev_crc_err = 0; ev_not_ready = 1; ev_xfer_done = 0; ev_setup_done = 0;
         @(negedge clk);
         ev_ep = 4'd9; ev_stall = 1;
         clr_valid = 1; clr_ep = 4'd9; clr_dir_in = 0; clr_mask = 8'hF0;
         @(negedge clk);
         ev_valid = 0; clr_valid = 0;
         while (busy && n < 20) begin n++; @(negedge clk); end
         check(mem[10'h1A0] == 8'h40, "R11 first op", mem[10'h1A0], 8'h40);
         check(mem[10'h1B0] == 8'hF0, "R11 busy request ignored", mem[10'h1B0], 8'hF0);
      end

      // random mix, R2 R3 R4 R5 R8 R9 R10
      for (int i = 0; i < 120; i++) begin
         logic ev_v, c_v;
         base_ptr = 16'($urandom_range(0, 767));
         ev_v = 1'($urandom);
         c_v  = ev_v ? 1'($urandom) : 1'b1;
         run_op(ev_v, 4'($urandom), 1'($urandom), 2'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                c_v, 4'($urandom), 1'($urandom), 8'($urandom), "R2 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule